// File: doc/BRIEF.md
# Video Layer Priority Selector

This block chooses, for every pixel, which of four colour sources reaches the display: black, the background colour, the sprite colour or an auxiliary graphics layer. A sprite pixel is present when any sprite bit plane is set. The background is present when its dedicated video bit is high. The selected colour and a 2-bit select code are captured in a register on the pixel clock enable.

The auxiliary layer can be given either the highest or the lowest priority. The mux feeds the auxiliary colour on two codes. One is the slot that shows black when nothing else is present. The other is a code that beats every other source. An active-low priority control chooses between the two. Two flags stand in for board-level pull resistors. When the control is flagged as undriven, it acts as high, so the auxiliary layer stays at low priority. When the auxiliary board is flagged absent, its colour reads as zero, so an empty pixel is black.

Top module: `vid_prio_sel`

## Requirements
- R1: While reset is asserted, and until the first enabled pixel after reset, `pix_col` is 0 and `pix_sel` is 2'b00, whatever the inputs are.
- R2: With high-priority auxiliary inactive and any bit of `spr_planes` set, the next pixel has `pix_sel` = 2'b10 and `pix_col` = `spr_col`.
- R3: With high-priority auxiliary inactive, no sprite plane set and `bg_on` high, the next pixel has `pix_sel` = 2'b01 and `pix_col` = `bg_col`.
- R4: With high-priority auxiliary inactive, no sprite plane set and `bg_on` low, the next pixel has `pix_sel` = 2'b00 and `pix_col` = the effective auxiliary colour.
- R5: High-priority auxiliary is active when `aux_top_n` is 0 and `aux_ctl_drv` is 1. In that case the next pixel has `pix_sel` = 2'b11 and `pix_col` = the effective auxiliary colour, regardless of the sprite and background inputs.
- R6: When `aux_ctl_drv` is 0, `aux_top_n` has no effect. The output is the same as when `aux_top_n` is 1.
- R7: When `aux_present` is 0, the effective auxiliary colour is 0 on both auxiliary codes. An empty pixel therefore comes out black. When `aux_present` is 1, the effective auxiliary colour is `aux_col`.
- R8: Outputs change only one clock after a cycle with `pix_ce` high, and they hold their value while `pix_ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_ce | input | 1 | Pixel clock enable |
| spr_planes | input | NPLANES | Sprite bit planes; any set bit means a sprite pixel |
| bg_on | input | 1 | Background video bit |
| spr_col | input | CW | Sprite colour |
| bg_col | input | CW | Background colour |
| aux_col | input | CW | Auxiliary layer colour |
| aux_top_n | input | 1 | Active-low control that puts the auxiliary layer on top |
| aux_ctl_drv | input | 1 | 1 when aux_top_n is driven; 0 makes it read as high |
| aux_present | input | 1 | 1 when the auxiliary board is fitted; 0 forces its colour to zero |
| pix_col | output | CW | Registered selected colour |
| pix_sel | output | 2 | Registered select code: 00 low aux/black, 01 background, 10 sprite, 11 top aux |

## Verification
The assertions check several rules on every cycle against the internal next-pixel values. The priority order and the forcing of an absent board to zero are checked this way. So is the rule that an undriven control never turns on the top auxiliary path, and that the output register captures on the enable and holds without it. The bench sweeps every combination of sprite planes, background bit, control, drive flag and board flag over several colour patterns. This is the only way to show that the outputs at the ports land one enabled clock later with the right value. The bench scenarios also show that the reset state survives nonzero inputs and that a disabled enable freezes the pixel.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    SEL_AUX_LO = 2'b00,
    SEL_BG     = 2'b01,
    SEL_SPR    = 2'b10,
    SEL_AUX_HI = 2'b11
  } vps_sel_e;
  localparam int NSRC = 4;
endpackage

// File: rtl/vps_rst_sync.sv
module vps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/vps_aux_cond.sv
module vps_aux_cond #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          aux_top_n,
  input  logic          aux_ctl_drv,
  input  logic          aux_present,
  input  logic [CW-1:0] aux_col,
  output logic          aux_hi_act,
  output logic [CW-1:0] aux_col_eff
);
  logic top_n_eff;

  always_comb begin
    top_n_eff   = aux_ctl_drv ? aux_top_n : 1'b1;
    aux_hi_act  = ~top_n_eff;
    aux_col_eff = aux_present ? aux_col : '0;
  end

  a_r6_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_ctl_drv |-> !aux_hi_act);
  a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_present |-> (aux_col_eff == '0));
endmodule

// File: rtl/vps_prio.sv
module vps_prio
  import vps_pkg::*;
#(
  parameter int CW      = 4,
  parameter int NPLANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPLANES-1:0] spr_planes,
  input  logic               bg_on,
  input  logic [CW-1:0]      spr_col,
  input  logic [CW-1:0]      bg_col,
  input  logic [CW-1:0]      aux_col_eff,
  input  logic               aux_hi_act,
  output vps_sel_e           sel_nxt,
  output logic [CW-1:0]      col_nxt
);
  logic              spr_any;
  logic [CW-1:0]     src [NSRC];

  assign spr_any = |spr_planes;

  always_comb begin
    src[SEL_AUX_LO] = aux_col_eff;
    src[SEL_BG]     = bg_col;
    src[SEL_SPR]    = spr_col;
    src[SEL_AUX_HI] = aux_col_eff;
  end

  always_comb begin
    if (aux_hi_act)   sel_nxt = SEL_AUX_HI;
    else if (spr_any) sel_nxt = SEL_SPR;
    else if (bg_on)   sel_nxt = SEL_BG;
    else              sel_nxt = SEL_AUX_LO;
  end

  assign col_nxt = src[sel_nxt];

  a_r5_aux_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    aux_hi_act |-> (sel_nxt == SEL_AUX_HI && col_nxt == aux_col_eff));
  a_r2_sprite_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_hi_act && (spr_planes != '0)) |-> (sel_nxt == SEL_SPR && col_nxt == spr_col));
  a_r3_bg_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_hi_act && (spr_planes == '0) && bg_on) |-> (sel_nxt == SEL_BG && col_nxt == bg_col));
  a_r4_aux_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_hi_act && (spr_planes == '0) && !bg_on) |-> (sel_nxt == SEL_AUX_LO && col_nxt == aux_col_eff));
endmodule

// File: rtl/vps_out_reg.sv
module vps_out_reg
  import vps_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  vps_sel_e      sel_nxt,
  input  logic [CW-1:0] col_nxt,
  output vps_sel_e      sel_q,
  output logic [CW-1:0] col_q
);
  vps_sel_e      sel_d;
  logic [CW-1:0] col_d;

  always_comb begin
    sel_d = sel_q;
    col_d = col_q;
    if (ce) begin
      sel_d = sel_nxt;
      col_d = col_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_AUX_LO;
      col_q <= '0;
    end else begin
      sel_q <= sel_d;
      col_q <= col_d;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(col_q) && $stable(sel_q)));
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (col_q == $past(col_nxt) && sel_q == $past(sel_nxt)));
endmodule

// File: rtl/vid_prio_sel.sv
module vid_prio_sel
  import vps_pkg::*;
#(
  parameter int CW      = 4,
  parameter int NPLANES = 2,
  parameter int RST_STG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_ce,
  input  logic [NPLANES-1:0] spr_planes,
  input  logic               bg_on,
  input  logic [CW-1:0]      spr_col,
  input  logic [CW-1:0]      bg_col,
  input  logic [CW-1:0]      aux_col,
  input  logic               aux_top_n,
  input  logic               aux_ctl_drv,
  input  logic               aux_present,
  output logic [CW-1:0]      pix_col,
  output logic [1:0]         pix_sel
);
  logic          rst_n_s;
  logic          aux_hi_act;
  logic [CW-1:0] aux_col_eff;
  vps_sel_e      sel_nxt;
  logic [CW-1:0] col_nxt;
  vps_sel_e      sel_q;

  vps_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  vps_aux_cond #(.CW(CW)) u_aux (
    .clk(clk), .rst_n(rst_n_s),
    .aux_top_n(aux_top_n), .aux_ctl_drv(aux_ctl_drv),
    .aux_present(aux_present), .aux_col(aux_col),
    .aux_hi_act(aux_hi_act), .aux_col_eff(aux_col_eff)
  );

  vps_prio #(.CW(CW), .NPLANES(NPLANES)) u_prio (
    .clk(clk), .rst_n(rst_n_s),
    .spr_planes(spr_planes), .bg_on(bg_on),
    .spr_col(spr_col), .bg_col(bg_col),
    .aux_col_eff(aux_col_eff), .aux_hi_act(aux_hi_act),
    .sel_nxt(sel_nxt), .col_nxt(col_nxt)
  );

  vps_out_reg #(.CW(CW)) u_out (
    .clk(clk), .rst_n(rst_n_s), .ce(pix_ce),
    .sel_nxt(sel_nxt), .col_nxt(col_nxt),
    .sel_q(sel_q), .col_q(pix_col)
  );

  assign pix_sel = sel_q;
endmodule

// File: tb/sim_vid_prio_sel.sv
module sim_vid_prio_sel;
  localparam int CW = 4;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_ce;
  logic [NP-1:0] spr_planes;
  logic          bg_on;
  logic [CW-1:0] spr_col, bg_col, aux_col;
  logic          aux_top_n, aux_ctl_drv, aux_present;
  logic [CW-1:0] pix_col;
  logic [1:0]    pix_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vid_prio_sel #(.CW(CW), .NPLANES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .spr_planes(spr_planes), .bg_on(bg_on),
    .spr_col(spr_col), .bg_col(bg_col), .aux_col(aux_col),
    .aux_top_n(aux_top_n), .aux_ctl_drv(aux_ctl_drv), .aux_present(aux_present),
    .pix_col(pix_col), .pix_sel(pix_sel)
  );

  task automatic check(input string req, input logic [1:0] exp_sel, input logic [CW-1:0] exp_col);
    checks++;
    if (pix_sel !== exp_sel || pix_col !== exp_col) begin
      errors++;
      $display("FAIL %s: sel=%b col=%h expected sel=%b col=%h", req, pix_sel, pix_col, exp_sel, exp_col);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_ce = 1'b1;
    spr_planes = 2'b11; bg_on = 1'b1;
    spr_col = 4'hF; bg_col = 4'hE; aux_col = 4'hD;
    aux_top_n = 1'b0; aux_ctl_drv = 1'b1; aux_present = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 in reset", 2'b00, 4'h0);
    pix_ce = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release, no enable", 2'b00, 4'h0);
    pix_ce = 1'b1;

    for (int pat = 0; pat < 4; pat++) begin
      for (int ctl = 0; ctl < 64; ctl++) begin
        logic [CW-1:0] aeff;
        logic hi;
        logic [1:0] es;
        logic [CW-1:0] ec;
        string req;
        spr_planes  = ctl[1:0];
        bg_on       = ctl[2];
        aux_top_n   = ctl[3];
        aux_ctl_drv = ctl[4];
        aux_present = ctl[5];
        spr_col = 4'hA ^ 4'(pat);
        bg_col  = 4'h5 ^ 4'(pat << 2);
        aux_col = 4'hC ^ 4'(pat * 3);
        aeff = aux_present ? aux_col : 4'h0;
        hi   = aux_ctl_drv && !aux_top_n;
        if (hi)                       begin es = 2'b11; ec = aeff;    req = "R5 aux on top"; end
        else if (spr_planes != 2'b00) begin es = 2'b10; ec = spr_col; req = "R2 sprite"; end
        else if (bg_on)               begin es = 2'b01; ec = bg_col;  req = "R3 background"; end
        else                          begin es = 2'b00; ec = aeff;    req = "R4 aux lowest"; end
        if (!aux_ctl_drv) req = {req, " R6 undriven"};
        if (!aux_present && (es == 2'b11 || es == 2'b00)) req = {req, " R7 absent black"};
        @(negedge clk);
        check(req, es, ec);
      end
    end

    // R8: capture one pattern, then disable and change inputs
    spr_planes = 2'b01; bg_on = 1'b0; aux_top_n = 1'b1; aux_ctl_drv = 1'b1;
    aux_present = 1'b1; spr_col = 4'h7;
    @(negedge clk);
    check("R8 capture", 2'b10, 4'h7);
    pix_ce = 1'b0;
    spr_planes = 2'b00; bg_on = 1'b1; bg_col = 4'h3;
    repeat (3) @(negedge clk);
    check("R8 hold while disabled", 2'b10, 4'h7);
    pix_ce = 1'b1;
    @(negedge clk);
    check("R8 update after enable", 2'b01, 4'h3);

    // R1: reset again mid-run forces black
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 2'b00, 4'h0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule